// File: doc/BRIEF.md
# Dual-Port Host FIFO Interface

This block is the host-facing front of a peripheral controller. A byte FIFO sits between a peripheral-side byte stream and two host ports. One host port is a plain 8-bit DMA data port with its own active-low read and write strobes. The other is an 8-bit processor port that carries a 4-bit register address and the register data on the same lines. Through that port the processor reaches a small register file, which includes a window onto the FIFO.

A direction bit in the control register decides which way bytes flow. When bytes flow toward the host, the peripheral stream fills the FIFO and either host port drains it. When bytes flow toward the peripheral, either host port fills the FIFO and the peripheral stream drains it. Each FIFO entry stores a parity bit beside the data byte. The peripheral side checks that bit on the way in and on the way out, and a test mode replaces the outgoing parity with data bit 7. The DMA port and the processor port work in the same cycle, except when the processor is touching the FIFO. In that case the DMA port is stalled for the cycle.

Top module: `hostFifoIf`

## Requirements
- R1: After reset the FIFO is empty, all sticky flags are clear, the control register reads 0x00, `dmaReady` is high and `perOutValid` is low.
- R2: The register address is the low nibble of `cpuAdIn`, sampled in the last cycle that `cpuAle` is high and latched when `cpuAle` falls. The address holds until the next falling edge of `cpuAle`.
- R3: Processor reads and writes take effect only while `cpuCsN` is low. A write with `cpuCsN` high changes nothing. `cpuAdOut` is 0x00 whenever no processor read is active.
- R4: Register map. Address 0x0 is the FIFO data window. Address 0x1 is status: bit0 empty, bit1 full, bit2 parity error, bits 7:3 fill count. Address 0x2 is control: bit0 direction (1 = toward the peripheral), bit1 parity test mode. Address 0x3 holds errors: bit0 overflow, bit1 underflow. Every other address reads 0x00.
- R5: With direction 0, only the peripheral stream pushes and only the host ports pop. With direction 1, only the host ports push and only the peripheral stream pops. A host FIFO access in the wrong direction is ignored and raises no flag.
- R6: A processor access to address 0x0 (read or write, under chip select) drives `dmaReady` low, and any DMA access in that cycle is not performed. Any other processor access leaves `dmaReady` high, and a DMA transfer completes in the same cycle.
- R7: While `dmaRdN` is low, `dmaDataOut` shows the oldest FIFO byte and `dmaParOut` shows its stored parity bit. The byte is removed at the clock edge that ends a cycle in which `dmaRdN` is low and `dmaReady` is high.
- R8: Parity is odd over the 8 data bits. A processor-written byte is stored with a freshly generated odd parity bit. DMA writes and peripheral pushes store the parity bit they supply.
- R9: With test mode set, `dmaParOut` and `perOutPar` both equal data bit 7 of the byte shown.
- R10: The sticky parity error flag is set in two cases: when a byte with even 9-bit parity is accepted from the peripheral stream, and when a byte with even stored parity is popped toward the peripheral. A processor read of address 0x1 clears the flag, but a new error in the same cycle wins.
- R11: A push when full is ignored and sets the sticky overflow flag. A pop when empty is ignored and sets the sticky underflow flag. A processor read of address 0x3 clears both flags.
- R12: Bytes leave in the order they entered, from whichever port. Full is reported at exactly DEPTH entries.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| cpuCsN | input | 1 | Processor chip select, active low |
| cpuAle | input | 1 | Address latch enable; address is taken on its falling edge |
| cpuRdN | input | 1 | Processor read strobe, active low |
| cpuWrN | input | 1 | Processor write strobe, active low |
| cpuAdIn | input | 8 | Multiplexed address/data from the processor |
| cpuAdOut | output | 8 | Register read data to the processor |
| dmaRdN | input | 1 | DMA read strobe, active low |
| dmaWrN | input | 1 | DMA write strobe, active low |
| dmaDataIn | input | 8 | DMA write data |
| dmaParIn | input | 1 | Parity bit with DMA write data |
| dmaDataOut | output | 8 | DMA read data |
| dmaParOut | output | 1 | Parity bit with DMA read data |
| dmaReady | output | 1 | Low when the DMA access is stalled by the processor |
| perInValid | input | 1 | Peripheral byte offered for push |
| perInData | input | 8 | Peripheral byte in |
| perInPar | input | 1 | Parity of peripheral byte in |
| perOutTake | input | 1 | Peripheral takes the shown byte |
| perOutValid | output | 1 | A byte is available toward the peripheral |
| perOutData | output | 8 | Byte toward the peripheral |
| perOutPar | output | 1 | Parity toward the peripheral |

## Verification
The bench builds the block with DEPTH set to 4. At that depth, four pushes fill the FIFO, so the full flag, a rejected fifth push with its overflow flag, and draining to empty followed by an underflow all fit in a short run. The shallow FIFO also makes the fill count in the status register cover its whole range from zero to full. Both directions are exercised, along with the collision between the DMA port and a processor access to the data window, and the parity test mode on each outgoing side.

// File: rtl/hfi_pkg.sv
package hfi_pkg;

  // Register addresses. The data window is where the port arbitration keys.
  localparam logic [3:0] ADDR_DATA = 4'h0;
  localparam logic [3:0] ADDR_STAT = 4'h1;
  localparam logic [3:0] ADDR_CTRL = 4'h2;
  localparam logic [3:0] ADDR_ERR  = 4'h3;

  localparam int CNT_FIELD_W = 5;

  typedef enum logic [1:0] {
    SRC_PER = 2'd0,
    SRC_DMA = 2'd1,
    SRC_CPU = 2'd2
  } pushSrcT;

  // Strobes from control to datapath, one FIFO operation of each kind per cycle.
  typedef struct packed {
    logic    push;
    logic    pop;
    pushSrcT pushSrc;
    logic    popToPer;
  } fifoStrobeT;

endpackage

// File: rtl/hfi_datapath.sv
module hfi_datapath
  import hfi_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH),
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  fifoStrobeT    stb,
  input  logic          testMode,
  input  logic [7:0]    perInData,
  input  logic          perInPar,
  input  logic [7:0]    dmaInData,
  input  logic          dmaInPar,
  input  logic [7:0]    cpuInData,
  output logic [7:0]    headData,
  output logic          outPar,
  output logic [CW-1:0] count,
  output logic          full,
  output logic          empty,
  output logic          parEvt
);

  localparam int WORD_W = 9;

  logic [WORD_W-1:0] mem [DEPTH];
  logic [AW-1:0]     wrPtr, rdPtr;
  logic [WORD_W-1:0] wrWord, headWord;
  logic              pushOk, popOk;
  logic              inBad, outBad;

  function automatic logic [AW-1:0] bump(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  assign full   = (count == CW'(DEPTH));
  assign empty  = (count == '0);
  assign pushOk = stb.push && !full;
  assign popOk  = stb.pop && !empty;

  always_comb begin
    unique case (stb.pushSrc)
      SRC_DMA: wrWord = {dmaInPar, dmaInData};
      SRC_CPU: wrWord = {~^cpuInData, cpuInData};
      default: wrWord = {perInPar, perInData};
    endcase
  end

  always_ff @(posedge clk) begin
    if (pushOk) mem[wrPtr] <= wrWord;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPtr <= '0;
      rdPtr <= '0;
      count <= '0;
    end else begin
      if (pushOk) wrPtr <= bump(wrPtr);
      if (popOk)  rdPtr <= bump(rdPtr);
      case ({pushOk, popOk})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assign headWord = mem[rdPtr];
  assign headData = headWord[7:0];
  assign outPar   = testMode ? headWord[7] : headWord[8];

  // Odd parity: a good 9-bit word has an odd number of ones.
  assign inBad  = pushOk && (stb.pushSrc == SRC_PER) && !(^{perInPar, perInData});
  assign outBad = popOk && stb.popToPer && !(^headWord);
  assign parEvt = inBad || outBad;

endmodule

// File: rtl/hfi_ctrl.sv
module hfi_ctrl
  import hfi_pkg::*;
#(
  parameter int CW = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          cpuCsN,
  input  logic          cpuAle,
  input  logic          cpuRdN,
  input  logic          cpuWrN,
  input  logic [7:0]    cpuAdIn,
  output logic [7:0]    cpuAdOut,
  input  logic          dmaRdN,
  input  logic          dmaWrN,
  output logic          dmaReady,
  input  logic          perInValid,
  input  logic          perOutTake,
  output logic          perOutValid,
  input  logic          full,
  input  logic          empty,
  input  logic [CW-1:0] count,
  input  logic          parEvt,
  input  logic [7:0]    headData,
  output fifoStrobeT    stb,
  output logic          testMode
);

  logic       alePrev;
  logic [3:0] adPrev;
  logic [3:0] regAddr;
  logic       dirToPer;
  logic       parErr, ovfErr, unfErr;
  logic       cpuRd, cpuWr, cpuFifoRd, cpuFifoWr;
  logic       dmaRd, dmaWr;
  logic       clrStat, clrErr;
  logic [CNT_FIELD_W-1:0] cntField;

  // Address latch: the nibble seen while the enable was high is kept on its fall.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      alePrev <= 1'b0;
      adPrev  <= '0;
      regAddr <= '0;
    end else begin
      alePrev <= cpuAle;
      if (cpuAle) adPrev <= cpuAdIn[3:0];
      if (alePrev && !cpuAle) regAddr <= adPrev;
    end
  end

  assign cpuRd     = !cpuCsN && !cpuRdN;
  assign cpuWr     = !cpuCsN && !cpuWrN && cpuRdN;
  assign cpuFifoRd = cpuRd && (regAddr == ADDR_DATA);
  assign cpuFifoWr = cpuWr && (regAddr == ADDR_DATA);

  // Processor wins the FIFO; DMA stalls for that cycle.
  assign dmaReady = !(cpuFifoRd || cpuFifoWr);
  assign dmaRd    = !dmaRdN && dmaReady;
  assign dmaWr    = !dmaWrN && dmaRdN && dmaReady;

  always_comb begin
    stb.popToPer = dirToPer;
    if (dirToPer) begin
      stb.push    = cpuFifoWr || dmaWr;
      stb.pushSrc = cpuFifoWr ? SRC_CPU : SRC_DMA;
      stb.pop     = perOutTake;
    end else begin
      stb.push    = perInValid;
      stb.pushSrc = SRC_PER;
      stb.pop     = cpuFifoRd || dmaRd;
    end
  end

  assign perOutValid = dirToPer && !empty;

  assign clrStat = cpuRd && (regAddr == ADDR_STAT);
  assign clrErr  = cpuRd && (regAddr == ADDR_ERR);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dirToPer <= 1'b0;
      testMode <= 1'b0;
      parErr   <= 1'b0;
      ovfErr   <= 1'b0;
      unfErr   <= 1'b0;
    end else begin
      if (cpuWr && (regAddr == ADDR_CTRL)) begin
        dirToPer <= cpuAdIn[0];
        testMode <= cpuAdIn[1];
      end
      parErr <= parEvt || (parErr && !clrStat);
      ovfErr <= (stb.push && full) || (ovfErr && !clrErr);
      unfErr <= (stb.pop && empty) || (unfErr && !clrErr);
    end
  end

  assign cntField = CNT_FIELD_W'(count);

  always_comb begin
    cpuAdOut = 8'h00;
    if (cpuRd) begin
      unique case (regAddr)
        ADDR_DATA: cpuAdOut = headData;
        ADDR_STAT: cpuAdOut = {cntField, parErr, full, empty};
        ADDR_CTRL: cpuAdOut = {6'b0, testMode, dirToPer};
        ADDR_ERR:  cpuAdOut = {6'b0, unfErr, ovfErr};
        default:   cpuAdOut = 8'h00;
      endcase
    end
  end

endmodule

// File: rtl/hostFifoIf.sv
module hostFifoIf
  import hfi_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cpuCsN,
  input  logic       cpuAle,
  input  logic       cpuRdN,
  input  logic       cpuWrN,
  input  logic [7:0] cpuAdIn,
  output logic [7:0] cpuAdOut,
  input  logic       dmaRdN,
  input  logic       dmaWrN,
  input  logic [7:0] dmaDataIn,
  input  logic       dmaParIn,
  output logic [7:0] dmaDataOut,
  output logic       dmaParOut,
  output logic       dmaReady,
  input  logic       perInValid,
  input  logic [7:0] perInData,
  input  logic       perInPar,
  input  logic       perOutTake,
  output logic       perOutValid,
  output logic [7:0] perOutData,
  output logic       perOutPar
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = $clog2(DEPTH + 1);

  fifoStrobeT    stb;
  logic          testMode;
  logic          fifoFull, fifoEmpty, parEvt, outPar;
  logic [CW-1:0] fifoCount;
  logic [7:0]    headData;

  hfi_ctrl #(.CW(CW)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .cpuCsN(cpuCsN), .cpuAle(cpuAle), .cpuRdN(cpuRdN), .cpuWrN(cpuWrN),
    .cpuAdIn(cpuAdIn), .cpuAdOut(cpuAdOut),
    .dmaRdN(dmaRdN), .dmaWrN(dmaWrN), .dmaReady(dmaReady),
    .perInValid(perInValid), .perOutTake(perOutTake), .perOutValid(perOutValid),
    .full(fifoFull), .empty(fifoEmpty), .count(fifoCount), .parEvt(parEvt),
    .headData(headData), .stb(stb), .testMode(testMode)
  );

  hfi_datapath #(.DEPTH(DEPTH), .AW(AW), .CW(CW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .testMode(testMode),
    .perInData(perInData), .perInPar(perInPar),
    .dmaInData(dmaDataIn), .dmaInPar(dmaParIn), .cpuInData(cpuAdIn),
    .headData(headData), .outPar(outPar), .count(fifoCount),
    .full(fifoFull), .empty(fifoEmpty), .parEvt(parEvt)
  );

  assign dmaDataOut = dmaRdN ? 8'h00 : headData;
  assign dmaParOut  = dmaRdN ? 1'b0 : outPar;
  assign perOutData = headData;
  assign perOutPar  = outPar;

endmodule

// File: rtl/hfi_checker.sv
module hfi_checker
  import hfi_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CW    = 5
) (
  input logic          clk,
  input logic          rstN,
  input logic          cpuCsN,
  input logic          cpuRdN,
  input logic          dmaRdN,
  input logic          dmaReady,
  input logic [7:0]    dmaDataOut,
  input logic          dmaParOut,
  input logic          perOutValid,
  input logic [7:0]    perOutData,
  input logic          perOutPar,
  input logic [7:0]    cpuAdOut,
  input fifoStrobeT    stb,
  input logic [CW-1:0] dpCount,
  input logic          dpFull,
  input logic          dpEmpty,
  input logic          testMode
);

  AST_STALL_NO_DMA_PUSH: assert property (@(posedge clk) disable iff (!rstN)
    !dmaReady |-> !(stb.push && stb.pushSrc == SRC_DMA)); // R6
  AST_STALL_NEEDS_CPU: assert property (@(posedge clk) disable iff (!rstN)
    !dmaReady |-> !cpuCsN); // R6
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (dpFull && !stb.pop) |=> dpFull); // R11
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    (dpEmpty && !stb.push) |=> dpEmpty); // R11
  AST_COUNT_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    dpCount <= CW'(DEPTH)); // R12
  AST_DMA_TEST_PAR: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && !dmaRdN) |-> (dmaParOut == dmaDataOut[7])); // R9
  AST_PER_TEST_PAR: assert property (@(posedge clk) disable iff (!rstN)
    (testMode && perOutValid) |-> (perOutPar == perOutData[7])); // R9
  AST_IDLE_READ_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    (cpuCsN || cpuRdN) |-> (cpuAdOut == 8'h00)); // R3

endmodule

bind hostFifoIf hfi_checker #(.DEPTH(DEPTH), .CW(CW)) u_chk (
  .clk(clk), .rstN(rstN), .cpuCsN(cpuCsN), .cpuRdN(cpuRdN),
  .dmaRdN(dmaRdN), .dmaReady(dmaReady), .dmaDataOut(dmaDataOut),
  .dmaParOut(dmaParOut), .perOutValid(perOutValid), .perOutData(perOutData),
  .perOutPar(perOutPar), .cpuAdOut(cpuAdOut), .stb(stb),
  .dpCount(fifoCount), .dpFull(fifoFull), .dpEmpty(fifoEmpty),
  .testMode(testMode)
);

// File: tb/sim_hostFifoIf.sv
module sim_hostFifoIf;
  localparam int CLK_PERIOD = 10;
  localparam int DEPTH = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cpuCsN = 1'b1, cpuAle = 1'b0, cpuRdN = 1'b1, cpuWrN = 1'b1;
  logic [7:0] cpuAdIn = 8'h00;
  logic [7:0] cpuAdOut;
  logic dmaRdN = 1'b1, dmaWrN = 1'b1;
  logic [7:0] dmaDataIn = 8'h00;
  logic dmaParIn = 1'b0;
  logic [7:0] dmaDataOut;
  logic dmaParOut, dmaReady;
  logic perInValid = 1'b0;
  logic [7:0] perInData = 8'h00;
  logic perInPar = 1'b0;
  logic perOutTake = 1'b0;
  logic perOutValid;
  logic [7:0] perOutData;
  logic perOutPar;

  int checks = 0;
  int errors = 0;
  bit done = 0;
  bit tbTest = 0;
  int popSrc = 0;      // 0 none, 1 DMA, 2 peripheral, 3 processor
  logic [8:0] sb[$];   // {parity, data} in push order
  logic [7:0] v;

  always #(CLK_PERIOD / 2) clk = ~clk;

  hostFifoIf #(.DEPTH(DEPTH)) u0 (.*);

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Monitor: compare every popped byte with the oldest scoreboard entry (R7 R12 R8 R9).
  always @(negedge clk) begin
    if (popSrc != 0) begin
      if (sb.size() == 0) begin
        check("R12 pop with empty scoreboard", 1, 0);
      end else begin
        logic [8:0] e;
        logic expPar;
        e = sb.pop_front();
        expPar = tbTest ? e[7] : e[8];
        case (popSrc)
          1: check("R7 dma pop", {dmaParOut, dmaDataOut}, {expPar, e[7:0]});
          2: check("R12 per pop", {perOutPar, perOutData}, {expPar, e[7:0]});
          default: check("R12 cpu pop", cpuAdOut, e[7:0]);
        endcase
      end
    end
  end

  task automatic tick; @(posedge clk); #1; endtask

  task automatic setAddr(input logic [3:0] a);
    cpuAle = 1'b1; cpuAdIn = {4'h0, a};
    tick;
    cpuAle = 1'b0; cpuAdIn = 8'hA5;
    tick;
  endtask

  task automatic cpuWrite(input logic [3:0] a, input logic [7:0] d, input bit push);
    setAddr(a);
    cpuCsN = 1'b0; cpuWrN = 1'b0; cpuAdIn = d;
    if (push) sb.push_back({~^d, d});
    tick;
    cpuCsN = 1'b1; cpuWrN = 1'b1;
  endtask

  task automatic cpuReadNow(input int src, output logic [7:0] r);
    cpuCsN = 1'b0; cpuRdN = 1'b0; popSrc = src;
    @(negedge clk); r = cpuAdOut;
    tick;
    cpuCsN = 1'b1; cpuRdN = 1'b1; popSrc = 0;
  endtask

  task automatic cpuRead(input logic [3:0] a, input int src, output logic [7:0] r);
    setAddr(a);
    cpuReadNow(src, r);
  endtask

  task automatic dmaRead(input int src);
    dmaRdN = 1'b0; popSrc = src;
    tick;
    dmaRdN = 1'b1; popSrc = 0;
  endtask

  task automatic dmaWrite(input logic [7:0] d, input logic p, input bit push);
    dmaWrN = 1'b0; dmaDataIn = d; dmaParIn = p;
    if (push) sb.push_back({p, d});
    tick;
    dmaWrN = 1'b1;
  endtask

  task automatic perPush(input logic [7:0] d, input logic p, input bit push);
    perInValid = 1'b1; perInData = d; perInPar = p;
    if (push) sb.push_back({p, d});
    tick;
    perInValid = 1'b0;
  endtask

  task automatic perPop;
    perOutTake = 1'b1; popSrc = 2;
    tick;
    perOutTake = 1'b0; popSrc = 0;
  endtask

  task automatic finishRun;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=running expected=finished");
      finishRun();
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    tick;

    // R1 reset state
    @(negedge clk);
    check("R1 dmaReady", dmaReady, 1);
    check("R1 perOutValid", perOutValid, 0);
    tick;
    cpuRead(4'h1, 0, v); check("R1 status", v, 8'h01);
    cpuRead(4'h2, 0, v); check("R1 control", v, 8'h00);
    cpuRead(4'h3, 0, v); check("R1 errors", v, 8'h00);

    // R2 latch on falling enable, hold afterwards
    cpuWrite(4'h2, 8'h02, 0);
    cpuRead(4'h2, 0, v); check("R2 latched address", v, 8'h02);
    cpuReadNow(0, v); check("R2 address held", v, 8'h02);
    // R3 write without chip select is ignored; idle read data is zero
    cpuCsN = 1'b1; cpuWrN = 1'b0; cpuRdN = 1'b0; cpuAdIn = 8'h00;
    @(negedge clk); check("R3 idle out", cpuAdOut, 8'h00);
    tick; cpuWrN = 1'b1; cpuRdN = 1'b1;
    cpuReadNow(0, v); check("R3 no write without cs", v, 8'h02);
    cpuWrite(4'h2, 8'h00, 0);
    cpuRead(4'h7, 0, v); check("R4 unmapped reads zero", v, 8'h00);

    // Fill toward host (direction 0), R12 full at DEPTH
    perPush(8'h11, 1'b1, 1);
    perPush(8'h80, 1'b0, 1);
    perPush(8'hFE, 1'b0, 1);
    perPush(8'h00, 1'b1, 1);
    check("R5 no per output in dir0", perOutValid, 0);
    cpuRead(4'h1, 0, v); check("R12 full status", v, 8'h22);
    perPush(8'h55, 1'b1, 0);
    cpuRead(4'h3, 0, v); check("R11 overflow set", v, 8'h01);
    cpuRead(4'h3, 0, v); check("R11 overflow cleared", v, 8'h00);
    cpuRead(4'h1, 0, v); check("R11 overflow ignored", v, 8'h22);

    // Drain: DMA, processor window, then a collision
    dmaRead(1);
    dmaRead(1);
    cpuRead(4'h0, 3, v);
    setAddr(4'h0);
    dmaRdN = 1'b0; cpuCsN = 1'b0; cpuRdN = 1'b0; popSrc = 3;
    @(negedge clk); check("R6 dma stalled", dmaReady, 0);
    tick;
    dmaRdN = 1'b1; cpuCsN = 1'b1; cpuRdN = 1'b1; popSrc = 0;
    cpuRead(4'h1, 0, v); check("R6 single pop on collision", v, 8'h01);
    cpuRead(4'h3, 0, v); check("R6 no stalled underflow", v, 8'h00);
    dmaRead(0);
    cpuRead(4'h3, 0, v); check("R11 underflow set", v, 8'h02);

    // R10 bad parity on entry, sticky then cleared by status read
    perPush(8'h03, 1'b0, 1);
    cpuRead(4'h1, 0, v); check("R10 in parity error", v, 8'h0C);
    cpuRead(4'h1, 0, v); check("R10 cleared by read", v, 8'h08);
    // R6 status read with DMA pop in the same cycle
    setAddr(4'h1);
    dmaRdN = 1'b0; cpuCsN = 1'b0; cpuRdN = 1'b0; popSrc = 1;
    @(negedge clk);
    check("R6 dma ready beside status read", dmaReady, 1);
    check("R6 status during concurrent pop", cpuAdOut, 8'h08);
    tick;
    dmaRdN = 1'b1; cpuCsN = 1'b1; cpuRdN = 1'b1; popSrc = 0;
    cpuRead(4'h1, 0, v); check("R6 concurrent pop done", v, 8'h01);

    // R5 wrong-direction host pushes ignored
    cpuWrite(4'h0, 8'h77, 0);
    dmaWrite(8'h66, 1'b0, 0);
    cpuRead(4'h1, 0, v); check("R5 host push ignored in dir0", v, 8'h01);
    cpuRead(4'h3, 0, v); check("R5 no flag", v, 8'h00);

    // Direction 1: hosts fill, peripheral drains (R8 R10)
    cpuWrite(4'h2, 8'h01, 0);
    check("R5 per valid empty", perOutValid, 0);
    cpuWrite(4'h0, 8'h3C, 1);
    dmaWrite(8'h81, 1'b1, 1);
    dmaWrite(8'h07, 1'b1, 1);
    dmaRead(0);
    cpuRead(4'h1, 0, v); check("R5 dma pop ignored in dir1", v, 8'h18);
    check("R5 per valid", perOutValid, 1);
    perPop();
    perPop();
    cpuRead(4'h1, 0, v); check("R10 good parity out", v, 8'h08);
    perPop();
    cpuRead(4'h1, 0, v); check("R10 bad parity out", v, 8'h05);

    // R9 test mode on the peripheral side
    cpuWrite(4'h2, 8'h03, 0); tbTest = 1;
    cpuWrite(4'h0, 8'h80, 1);
    perPop();
    cpuRead(4'h1, 0, v); check("R9 test parity not an error", v, 8'h01);
    // R9 test mode on the DMA side
    cpuWrite(4'h2, 8'h02, 0);
    perPush(8'h83, 1'b0, 1);
    dmaRead(1);
    cpuRead(4'h1, 0, v); check("R9 drained", v, 8'h01);

    done = 1;
    finishRun();
  end
endmodule